// File: doc/BRIEF.md
# SD/eMMC card clock generator

This block produces the bus clock that an SD/eMMC host drives to the card, together with two companion clocks of the same frequency: one that launches transmit data and one that samples receive data. It runs in a single system clock domain. Two tick inputs, `ref_tick` for the slow reference rate and `fast_tick` for the fast rate, stand in for the two source clocks. A register chooses one of them, divides it, and applies a quarter-period phase shift to each of the three outputs independently.

Software programs the block through a simple write port that has two registers. The clock register holds the divider, the source select and the three phase codes. The configuration register holds the stop, automatic-gating, always-on and double-data-rate bits. The outputs never show a shortened high pulse. This holds when software reprograms the block, stops it, or lets it gate itself while the bus is idle: every output finishes its current high phase and is then parked low. New settings are loaded only after all three outputs are low. The double-data-rate bit does not act on the clocks. It is passed to the downstream data logic on `ddr_mode`.

The block has no data stream, so every pin is a plain level or strobe. A register write takes effect on the first clock edge on which `wr_en` is high.

Top module: `cardclk_gen`

## Requirements
- R1: After reset all three output clocks are low. While the divide field (clock register bits [5:0]) is 0, all three outputs stay low.
- R2: With a divide value D of 1 to 63, each output has a period of 2·D source ticks and stays high for exactly D ticks.
- R3: Each output has a 2-bit phase code p (0, 1, 2, 3 = 0°, 90°, 180°, 270°). The card clock's code is at clock register bits [9:8], transmit at [11:10] and receive at [13:12]. Code p delays that output's rising edge by (p·D+1)/2 ticks (integer division) modulo 2·D, relative to phase 0.
- R4: For odd D, the 90° and 270° codes round half a tick upward. For D=3 the offsets are 2 and 5 ticks. For D=1 the 90° offset is 1 tick and the 270° offset wraps to 0.
- R5: Clock register bit 6 selects the source: 0 counts `ref_tick` and 1 counts `fast_tick`.
- R6: While configuration bit 22 (stop) is set, the outputs finish any high phase in progress and then stay low. Clearing the bit restarts them.
- R7: Every high pulse on every output lasts exactly D ticks of the settings in force. This holds across reprogramming, stopping and idle gating. New clock-register values are applied only once all outputs are low.
- R8: When configuration bit 23 (auto) is set and bit 18 (always-on) is clear, the clocks run only while `bus_busy` is high. When bit 18 is set, the clocks run regardless of `bus_busy`.
- R9: `ddr_mode` equals configuration bit 2 from the clock edge that writes the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable at the reference source rate |
| fast_tick | input | 1 | One-cycle enable at the fast source rate |
| bus_busy | input | 1 | High while a transfer is in progress |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the clock register, 1 the configuration register |
| wr_data | input | 32 | Write data |
| card_clk | output | 1 | Card bus clock |
| tx_clk | output | 1 | Transmit launch clock |
| rx_clk | output | 1 | Receive sampling clock |
| ddr_mode | output | 1 | Double-data-rate flag for the data path |

## Verification
A wrong tick counter or a wrong loaded divider appears at the pins within one card clock period, as a period or high time that differs from 2·D and D. A wrong phase offset appears as a shifted rising edge of the transmit or receive clock relative to the card clock, within the same period. A gate stuck open or stuck closed appears within two periods, either as rising edges that continue after a stop or idle request or as a clock that never restarts. A reload that happens too early shows up as one high pulse whose width matches neither the old divide value nor the new one.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
  // field positions of the clock register
  localparam int unsigned SRC_BIT  = 6;
  localparam int unsigned PH_LSB   = 8;   // card, tx, rx codes follow in 2-bit steps
  // field positions of the configuration register
  localparam int unsigned DDR_BIT  = 2;
  localparam int unsigned AON_BIT  = 18;
  localparam int unsigned STOP_BIT = 22;
  localparam int unsigned AUTO_BIT = 23;
  // output lanes: 0 card, 1 transmit, 2 receive
  localparam int unsigned NUM_OUT  = 3;

  typedef logic [1:0] phase_t;
endpackage

// File: rtl/cardclk_regs.sv
module cardclk_regs
  import cardclk_pkg::*;
#(
  parameter int unsigned DIV_W = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           wr_addr,
  input  logic [31:0]                    wr_data,
  output logic [DIV_W-1:0]               prog_div,
  output logic                           prog_src,
  output logic [NUM_OUT-1:0][1:0]        prog_phase,
  output logic                           cfg_ddr,
  output logic                           cfg_aon,
  output logic                           cfg_stop,
  output logic                           cfg_auto
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_div   <= '0;
      prog_src   <= 1'b0;
      prog_phase <= '0;
      cfg_ddr    <= 1'b0;
      cfg_aon    <= 1'b0;
      cfg_stop   <= 1'b0;
      cfg_auto   <= 1'b0;
    end else if (wr_en) begin
      if (!wr_addr) begin
        prog_div <= wr_data[DIV_W-1:0];
        prog_src <= wr_data[SRC_BIT];
        for (int i = 0; i < NUM_OUT; i++) begin
          prog_phase[i] <= wr_data[PH_LSB + 2*i +: 2];
        end
      end else begin
        cfg_ddr  <= wr_data[DDR_BIT];
        cfg_aon  <= wr_data[AON_BIT];
        cfg_stop <= wr_data[STOP_BIT];
        cfg_auto <= wr_data[AUTO_BIT];
      end
    end
  end
endmodule

// File: rtl/cardclk_seq.sv
module cardclk_seq
  import cardclk_pkg::*;
#(
  parameter int unsigned DIV_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_tick,
  input  logic                    fast_tick,
  input  logic                    run_req,
  input  logic [DIV_W-1:0]        prog_div,
  input  logic                    prog_src,
  input  logic [NUM_OUT-1:0][1:0] prog_phase,
  input  logic [NUM_OUT-1:0]      gate_open,
  output logic [DIV_W:0]          cnt_q,
  output logic [DIV_W:0]          cnt_nxt,
  output logic [DIV_W-1:0]        act_div,
  output logic [NUM_OUT-1:0][1:0] act_phase,
  output logic                    want,
  output logic                    tick
);
  localparam int unsigned CW = DIV_W + 1;

  logic          act_src;
  logic          parked;
  logic          pending;
  logic          reload;
  logic [CW-1:0] per_last;

  assign tick     = act_src ? fast_tick : ref_tick;
  assign parked   = ~|gate_open;
  assign pending  = (prog_div != act_div) || (prog_src != act_src) ||
                    (prog_phase != act_phase);
  assign want     = run_req & ~pending;
  // shadow settings load and the counter rewinds only while every lane is parked low
  assign reload   = parked & ~want;
  assign per_last = {act_div, 1'b0} - CW'(1);

  always_comb begin
    if (reload) begin
      cnt_nxt = '0;
    end else if (tick) begin
      cnt_nxt = (cnt_q == per_last) ? '0 : cnt_q + CW'(1);
    end else begin
      cnt_nxt = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      act_div   <= '0;
      act_src   <= 1'b0;
      act_phase <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      if (reload) begin
        act_div   <= prog_div;
        act_src   <= prog_src;
        act_phase <= prog_phase;
      end
    end
  end
endmodule

// File: rtl/cardclk_phase.sv
module cardclk_phase
  import cardclk_pkg::*;
#(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W:0]   cnt_nxt,
  input  logic [DIV_W-1:0] div,
  input  phase_t           phase,
  input  logic             want,
  output logic             clk_out,
  output logic             gate_open
);
  localparam int unsigned W2 = DIV_W + 2;

  logic [W2-1:0] per;
  logic [W2-1:0] off;
  logic [W2-1:0] pos_ext;
  logic [W2-1:0] pos;
  logic          w_nxt;
  logic          g_nxt;

  always_comb begin
    per     = W2'({div, 1'b0});
    off     = (W2'(phase) * W2'(div) + W2'(1)) >> 1;
    pos_ext = W2'(cnt_nxt);
    if (pos_ext >= off) begin
      pos = pos_ext - off;
    end else begin
      pos = pos_ext + per - off;
    end
    w_nxt = (pos < W2'(div));
    // the gate may change only while this lane's waveform is low
    g_nxt = w_nxt ? gate_open : want;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_open <= 1'b0;
      clk_out   <= 1'b0;
    end else begin
      gate_open <= g_nxt;
      clk_out   <= g_nxt & w_nxt;
    end
  end
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
  import cardclk_pkg::*;
#(
  parameter int unsigned DIV_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_tick,
  input  logic        fast_tick,
  input  logic        bus_busy,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  output logic        card_clk,
  output logic        tx_clk,
  output logic        rx_clk,
  output logic        ddr_mode
);
  logic [DIV_W-1:0]        prog_div;
  logic                    prog_src;
  logic [NUM_OUT-1:0][1:0] prog_phase;
  logic                    cfg_ddr, cfg_aon, cfg_stop, cfg_auto;
  logic                    run_req;
  logic [DIV_W:0]          cnt_q, cnt_nxt;
  logic [DIV_W-1:0]        act_div;
  logic [NUM_OUT-1:0][1:0] act_phase;
  logic                    want, tick;
  logic [NUM_OUT-1:0]      outs, gates;

  cardclk_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_div(prog_div), .prog_src(prog_src), .prog_phase(prog_phase),
    .cfg_ddr(cfg_ddr), .cfg_aon(cfg_aon), .cfg_stop(cfg_stop), .cfg_auto(cfg_auto)
  );

  assign run_req = (prog_div != '0) & ~cfg_stop & (cfg_aon | ~cfg_auto | bus_busy);

  cardclk_seq #(.DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fast_tick(fast_tick),
    .run_req(run_req), .prog_div(prog_div), .prog_src(prog_src),
    .prog_phase(prog_phase), .gate_open(gates), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
    .act_div(act_div), .act_phase(act_phase), .want(want), .tick(tick)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
    cardclk_phase #(.DIV_W(DIV_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .cnt_nxt(cnt_nxt), .div(act_div),
      .phase(act_phase[i]), .want(want), .clk_out(outs[i]), .gate_open(gates[i])
    );
  end

  assign card_clk = outs[0];
  assign tx_clk   = outs[1];
  assign rx_clk   = outs[2];
  assign ddr_mode = cfg_ddr;
endmodule

// File: rtl/cardclk_chk.sv
module cardclk_chk #(
  parameter int unsigned DIV_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             card_clk,
  input logic [DIV_W-1:0] act_div,
  input logic [DIV_W:0]   cnt,
  input logic             cfg_stop,
  input logic             wr_en,
  input logic             wr_addr,
  input logic             wr_ddr,
  input logic             ddr_mode
);
  logic [DIV_W:0] hi_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_ticks <= '0;
    end else if (!card_clk) begin
      hi_ticks <= '0;
    end else if (tick) begin
      hi_ticks <= hi_ticks + 1'b1;
    end
  end

  p_cnt_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (act_div == '0) |-> (cnt == '0));

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_div != '0) |-> (cnt < {act_div, 1'b0}));

  p_no_runt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_clk) |-> (hi_ticks == {1'b0, act_div}));

  p_stop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stop && $past(cfg_stop) && !card_clk) |=> !card_clk);

  p_ddr_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && wr_addr) |-> (ddr_mode == $past(wr_ddr)));
endmodule

bind cardclk_gen cardclk_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .card_clk(card_clk), .act_div(act_div),
  .cnt(cnt_q), .cfg_stop(cfg_stop), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_ddr(wr_data[cardclk_pkg::DDR_BIT]), .ddr_mode(ddr_mode)
);

// File: tb/tb_cardclk_gen.sv
module tb_cardclk_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        fast_tick = 1'b1;
  logic        bus_busy = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        card_clk, tx_clk, rx_clk, ddr_mode;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int rise_t[3];
  int per_t[3];
  int last_w[3];
  int nrise[3];
  bit prev[3];
  bit seen[3];
  bit cur[3];
  int ok_a = 0;
  int ok_b = 0;
  int width_bad = 0;
  int cur_w = 0;

  cardclk_gen dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fast_tick(fast_tick),
    .bus_busy(bus_busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .card_clk(card_clk), .tx_clk(tx_clk), .rx_clk(rx_clk), .ddr_mode(ddr_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // edge monitor, away from the active edge
  always @(negedge clk) begin
    cur[0] = (card_clk === 1'b1);
    cur[1] = (tx_clk === 1'b1);
    cur[2] = (rx_clk === 1'b1);
    for (int i = 0; i < 3; i++) begin
      if (cur[i] && !prev[i]) begin
        if (seen[i]) per_t[i] = cyc - rise_t[i];
        rise_t[i] = cyc;
        seen[i] = 1'b1;
        nrise[i]++;
      end
      if (!cur[i] && prev[i] && seen[i]) begin
        last_w[i] = cyc - rise_t[i];
        if (last_w[i] != ok_a && last_w[i] != ok_b) width_bad++;
      end
      prev[i] = cur[i];
    end
  end

  initial begin
    int rc = 0;
    forever begin
      @(negedge clk);
      rc = (rc + 1) % 3;
      ref_tick = (rc == 0);
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    summary();
    $finish;
  end

  task automatic chk(bit c, string tag, int act, int exp);
    total++;
    if (!c) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [31:0] clk_word(int div, int src, int co, int tx, int rx);
    return 32'(div) | (32'(src) << 6) | (32'(co) << 8) | (32'(tx) << 10) | (32'(rx) << 12);
  endfunction

  function automatic logic [31:0] cfg_word(int ddr, int aon, int stp, int aut);
    return (32'(ddr) << 2) | (32'(aon) << 18) | (32'(stp) << 22) | (32'(aut) << 23);
  endfunction

  function automatic int off_of(int p, int div);
    return (p * div + 1) / 2;
  endfunction

  function automatic int exp_delta(int pa, int pb, int div);
    int per = 2 * div;
    return (((off_of(pb, div) - off_of(pa, div)) % per) + per) % per;
  endfunction

  function automatic int meas_delta(int ta, int tb, int per);
    return (((tb - ta) % per) + per) % per;
  endfunction

  task automatic apply_clk(int div, int src, int co, int tx, int rx);
    int nw = div * ((src != 0) ? 1 : 3);
    ok_a = cur_w;
    ok_b = nw;
    wr(1'b0, clk_word(div, src, co, tx, rx));
    wait_n(12 * (cur_w + nw) + 80);
    cur_w = nw;
  endtask

  initial begin
    int n0;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(card_clk === 1'b0, "R1 reset card_clk", int'(card_clk), 0);
    chk(tx_clk === 1'b0, "R1 reset tx_clk", int'(tx_clk), 0);
    chk(rx_clk === 1'b0, "R1 reset rx_clk", int'(rx_clk), 0);
    wr(1'b1, cfg_word(0, 0, 0, 0));
    wait_n(200);
    chk(nrise[0] == 0, "R1 divide 0 keeps card_clk low", nrise[0], 0);

    // R2 / R3: directed and random divide values and phase codes
    for (int k = 0; k < 24; k++) begin
      int div, co, tx, rx;
      case (k)
        0: div = 1;
        1: div = 2;
        2: div = 3;
        3: div = 63;
        default: div = int'($urandom_range(1, 63));
      endcase
      co = int'($urandom_range(0, 3));
      tx = int'($urandom_range(0, 3));
      rx = int'($urandom_range(0, 3));
      apply_clk(div, 1, co, tx, rx);
      chk(per_t[0] == 2 * div, "R2 card_clk period", per_t[0], 2 * div);
      chk(last_w[0] == div, "R2 card_clk high time", last_w[0], div);
      chk(meas_delta(rise_t[0], rise_t[1], 2 * div) == exp_delta(co, tx, div),
          "R3 tx_clk phase offset", meas_delta(rise_t[0], rise_t[1], 2 * div), exp_delta(co, tx, div));
      chk(meas_delta(rise_t[0], rise_t[2], 2 * div) == exp_delta(co, rx, div),
          "R3 rx_clk phase offset", meas_delta(rise_t[0], rise_t[2], 2 * div), exp_delta(co, rx, div));
    end

    // R4: odd divide rounding
    apply_clk(3, 1, 0, 1, 3);
    chk(meas_delta(rise_t[0], rise_t[1], 6) == 2, "R4 D=3 90 deg", meas_delta(rise_t[0], rise_t[1], 6), 2);
    chk(meas_delta(rise_t[0], rise_t[2], 6) == 5, "R4 D=3 270 deg", meas_delta(rise_t[0], rise_t[2], 6), 5);
    apply_clk(1, 1, 0, 1, 3);
    chk(meas_delta(rise_t[0], rise_t[1], 2) == 1, "R4 D=1 90 deg", meas_delta(rise_t[0], rise_t[1], 2), 1);
    chk(meas_delta(rise_t[0], rise_t[2], 2) == 0, "R4 D=1 270 deg", meas_delta(rise_t[0], rise_t[2], 2), 0);

    // R5: reference source (one tick every third cycle)
    apply_clk(5, 0, 0, 2, 0);
    chk(per_t[0] == 30, "R5 reference source period", per_t[0], 30);
    chk(last_w[0] == 15, "R5 reference source high time", last_w[0], 15);
    chk(meas_delta(rise_t[0], rise_t[1], 30) == 15, "R5 reference 180 deg", meas_delta(rise_t[0], rise_t[1], 30), 15);
    apply_clk(4, 1, 0, 1, 2);

    // R6: stop and resume
    wr(1'b1, cfg_word(0, 0, 1, 0));
    wait_n(200);
    n0 = nrise[0] + nrise[1] + nrise[2];
    wait_n(200);
    chk(nrise[0] + nrise[1] + nrise[2] == n0, "R6 stopped, no edges",
        nrise[0] + nrise[1] + nrise[2], n0);
    chk(card_clk === 1'b0, "R6 stopped level", int'(card_clk), 0);
    wr(1'b1, cfg_word(0, 0, 0, 0));
    wait_n(200);
    chk(nrise[0] > n0 / 3, "R6 resumed after clear", nrise[0], n0 / 3 + 1);

    // R8: automatic gating and always-on override
    bus_busy = 1'b0;
    wr(1'b1, cfg_word(0, 0, 0, 1));
    wait_n(200);
    n0 = nrise[0];
    wait_n(200);
    chk(nrise[0] == n0, "R8 idle bus gates clock", nrise[0], n0);
    bus_busy = 1'b1;
    wait_n(200);
    chk(nrise[0] > n0, "R8 busy bus runs clock", nrise[0], n0 + 1);
    bus_busy = 1'b0;
    wr(1'b1, cfg_word(0, 1, 0, 1));
    wait_n(100);
    n0 = nrise[0];
    wait_n(200);
    chk(nrise[0] > n0, "R8 always-on overrides idle", nrise[0], n0 + 1);

    // R7: random busy toggling under automatic gating
    wr(1'b1, cfg_word(0, 0, 0, 1));
    for (int j = 0; j < 120; j++) begin
      bus_busy = ($urandom_range(0, 1) != 0);
      wait_n(int'($urandom_range(1, 40)));
    end
    bus_busy = 1'b0;
    wait_n(60);
    chk(width_bad == 0, "R7 full pulses under idle gating", width_bad, 0);

    // R9: double-data-rate flag
    wr(1'b1, cfg_word(1, 0, 0, 0));
    chk(ddr_mode === 1'b1, "R9 ddr flag set", int'(ddr_mode), 1);
    wr(1'b1, cfg_word(0, 0, 0, 0));
    chk(ddr_mode === 1'b0, "R9 ddr flag clear", int'(ddr_mode), 0);

    // R1: divide 0 while running
    ok_a = cur_w; ok_b = cur_w;
    wr(1'b0, clk_word(0, 1, 0, 0, 0));
    wait_n(200);
    n0 = nrise[0];
    wait_n(200);
    chk(nrise[0] == n0 && card_clk === 1'b0, "R1 divide 0 stops running clock", nrise[0], n0);

    chk(width_bad == 0, "R7 no runt pulse on any lane", width_bad, 0);
    summary();
    $finish;
  end
endmodule